// File: doc/BRIEF.md
# Working-Set Clock Eviction Selector

This block picks the page frame to give up when a new page must be brought in. It keeps a small table with one entry per frame. Each entry holds a referenced flag, a modified flag, a writeback-pending flag and the time the page was last seen in use. A hand pointer marks where the next search starts. After an eviction request, the hand visits one frame per clock cycle in ring order. Recently used pages get their flag cleared and their timestamp refreshed. Old clean pages are taken. Old modified pages are sent out for writeback and skipped over.

A page counts as old when the time since its last use, taken modulo 2^16, is strictly greater than the window input. A full lap can end with nothing taken. If a writeback went out in that lap, or one is still outstanding, the search goes on. Otherwise the first unmodified frame from the hand onward is taken. If every frame is modified, the frame under the hand is taken.

Around the block, the host reports page accesses, signals writeback completion, and announces each freshly loaded page with a load strobe.

Top module: `wsclock_victim_engine`

## Requirements
- R1: After reset, no strobe is active and the engine is idle. The hand is at frame 0, and every frame is unreferenced and clean with timestamp 0.
- R2: An eviction request is accepted only when idle. Requests made while a search runs are ignored. From acceptance, the frame under the hand is examined on the next cycle, then one further frame per cycle in ring order. The victim strobe comes N cycles after acceptance, where N is the number of frames examined.
- R3: A frame examined with its referenced flag set is not taken. The flag is cleared and the timestamp is set to the current time.
- R4: A page is old only when (now - stamp) mod 2^16 > window. Equality counts as young, and the subtraction wraps.
- R5: An unreferenced, old, clean frame under the hand is taken. This gives a one-cycle victim strobe carrying its index, and the engine returns to idle.
- R6: An unreferenced, old, modified frame with no writeback outstanding produces a one-cycle writeback strobe with its index. The frame is marked pending and is not taken.
- R7: When a lap ends with a writeback issued in it or still pending, a new lap starts without selecting a victim.
- R8: When a lap ends with no writeback issued or pending, the first clean frame from the lap's start is taken. If all frames are modified, the lap-start frame (the one under the hand) is taken.
- R9: After a victim is chosen, the hand points to the frame after it, wrapping from the last frame to 0.
- R10: A load strobe makes its frame unreferenced, clean and not pending, with stamp = now. An access sets the referenced flag, and a write access also sets the modified flag. A writeback completion clears the modified and pending flags.
- R11: An access to the frame being examined, in the same cycle, counts as a reference, so that frame is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | 16 | Current time |
| tau | input | 16 | Working-set window |
| evict_req | input | 1 | Start a victim search |
| acc_valid | input | 1 | Page access strobe |
| acc_frame | input | 3 | Frame accessed |
| acc_write | input | 1 | Access was a write |
| load_valid | input | 1 | Freshly loaded page strobe |
| load_frame | input | 3 | Frame loaded |
| wb_done_valid | input | 1 | Writeback completed strobe |
| wb_done_frame | input | 3 | Frame whose writeback completed |
| wb_req_valid | output | 1 | Writeback request strobe |
| wb_req_frame | output | 3 | Frame to write back |
| victim_valid | output | 1 | Victim chosen (done strobe) |
| victim_frame | output | 3 | Chosen frame |
| busy | output | 1 | Search in progress |

## Verification
A host access can land on the very frame the hand is examining, in the same cycle. The access sets the referenced flag, while the examination would clear it or take the frame. The bench provokes this by driving an access to frame 0 in the cycle right after the request is accepted, with every page old and clean. The design must skip frame 0 and take frame 1 two cycles after acceptance. A second case joins writeback completions to lap-boundary decisions: a writeback issued on the last frame of a lap must force a further lap instead of a fallback.

// File: rtl/wsc_pkg.sv
// Package: shared constants and types of the eviction selector.
// Assumes: defaults are the values used by the top module.
package wsc_pkg;
    localparam int WSC_FRAMES  = 8;
    localparam int WSC_TIME_W  = 16;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_state_t;
endpackage

// File: rtl/wsc_age_test.sv
// Module: decides whether a page lies outside the working-set window.
// Assumes: timestamps wrap modulo 2^TS_W; "old" means strictly greater.
module wsc_age_test #(
    parameter int TS_W = 16
) (
    input  logic [TS_W-1:0] now,
    input  logic [TS_W-1:0] stamp,
    input  logic [TS_W-1:0] window,
    output logic            is_old
);
    logic [TS_W-1:0] age;

    // Wrapping age followed by a strict comparison against the window.
    always_comb begin
        age    = now - stamp;
        is_old = (age > window);
    end
endmodule

// File: rtl/wsc_frame_table.sv
// Module: per-frame state (referenced, modified, pending, last-use stamp).
// Assumes: at most one load, one access, one completion, one scan clear
// and one pending-set per cycle; load has top priority on every field.
module wsc_frame_table #(
    parameter int NF    = 8,
    parameter int TS_W  = 16,
    parameter int IDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TS_W-1:0]          now,
    input  logic                     acc_valid,
    input  logic [IDX_W-1:0]         acc_frame,
    input  logic                     acc_write,
    input  logic                     load_valid,
    input  logic [IDX_W-1:0]         load_frame,
    input  logic                     wbd_valid,
    input  logic [IDX_W-1:0]         wbd_frame,
    input  logic                     clr_en,
    input  logic [IDX_W-1:0]         clr_frame,
    input  logic                     pend_en,
    input  logic [IDX_W-1:0]         pend_frame,
    output logic [NF-1:0]            ref_vec,
    output logic [NF-1:0]            dirty_vec,
    output logic [NF-1:0]            pend_vec,
    output logic [NF-1:0][TS_W-1:0]  stamp_vec
);
    for (genvar g = 0; g < NF; g++) begin : g_frame
        logic hit_ld, hit_acc, hit_wbd, hit_clr, hit_pend;

        // Decode which strobes address this frame.
        always_comb begin
            hit_ld   = load_valid && (load_frame == IDX_W'(g));
            hit_acc  = acc_valid  && (acc_frame  == IDX_W'(g));
            hit_wbd  = wbd_valid  && (wbd_frame  == IDX_W'(g));
            hit_clr  = clr_en     && (clr_frame  == IDX_W'(g));
            hit_pend = pend_en    && (pend_frame == IDX_W'(g));
        end

        // Referenced flag: load clears, access sets, scan clears.
        always_ff @(posedge clk) begin
            if (!rst_n)        ref_vec[g] <= 1'b0;
            else if (hit_ld)   ref_vec[g] <= 1'b0;
            else if (hit_acc)  ref_vec[g] <= 1'b1;
            else if (hit_clr)  ref_vec[g] <= 1'b0;
        end

        // Last-use stamp: refreshed on load and on a scan clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                 stamp_vec[g] <= '0;
            else if (hit_ld || hit_clr) stamp_vec[g] <= now;
        end

        // Modified flag: load clears, write sets, completion clears.
        always_ff @(posedge clk) begin
            if (!rst_n)                     dirty_vec[g] <= 1'b0;
            else if (hit_ld)                dirty_vec[g] <= 1'b0;
            else if (hit_acc && acc_write)  dirty_vec[g] <= 1'b1;
            else if (hit_wbd)               dirty_vec[g] <= 1'b0;
        end

        // Pending flag: set on issue, cleared by load or completion.
        always_ff @(posedge clk) begin
            if (!rst_n)                   pend_vec[g] <= 1'b0;
            else if (hit_ld || hit_wbd)   pend_vec[g] <= 1'b0;
            else if (hit_pend)            pend_vec[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/wsc_clean_pick.sv
// Module: finds the first clean frame in ring order from a start index.
// Assumes: purely combinational; idx equals start when nothing is clean.
module wsc_clean_pick #(
    parameter int NF    = 8,
    parameter int IDX_W = 3
) (
    input  logic [NF-1:0]    dirty_vec,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Ring-ordered priority search over the modified flags.
    always_comb begin
        found = 1'b0;
        idx   = start;
        for (int k = 0; k < NF; k++) begin
            int p;
            p = int'(start) + k;
            if (p >= NF) p = p - NF;
            if (!found && !dirty_vec[IDX_W'(p)]) begin
                found = 1'b1;
                idx   = IDX_W'(p);
            end
        end
    end
endmodule

// File: rtl/wsc_scan_ctrl.sv
// Module: hand pointer and search sequencer, one frame per cycle.
// Assumes: frame state comes from the table; age of the frame under the
// hand is supplied; a same-cycle access to that frame counts as a reference.
module wsc_scan_ctrl
    import wsc_pkg::*;
#(
    parameter int NF    = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evict_req,
    input  logic [NF-1:0]    ref_vec,
    input  logic [NF-1:0]    dirty_vec,
    input  logic [NF-1:0]    pend_vec,
    input  logic             hand_old,
    input  logic             acc_hit,
    input  logic             pick_found,
    input  logic [IDX_W-1:0] pick_idx,
    output logic [IDX_W-1:0] hand,
    output logic [IDX_W-1:0] hand_nxt,
    output logic             busy,
    output logic             clr_en,
    output logic             pend_en,
    output logic             wb_req_valid,
    output logic [IDX_W-1:0] wb_req_frame,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_frame
);
    scan_state_t      state;
    logic [IDX_W-1:0] lap_cnt;
    logic             lap_sched;
    logic             eff_ref, take_here, issue_wb, lap_end;
    logic             go_on, fallback, take_any;
    logic [IDX_W-1:0] take_idx;

    function automatic logic [IDX_W-1:0] ring_inc(input logic [IDX_W-1:0] x);
        return (x == IDX_W'(NF - 1)) ? '0 : x + 1'b1;
    endfunction

    // Per-cycle decision for the frame under the hand.
    always_comb begin
        busy      = (state == SC_SCAN);
        hand_nxt  = ring_inc(hand);
        eff_ref   = ref_vec[hand] || acc_hit;
        take_here = !eff_ref && hand_old && !dirty_vec[hand];
        issue_wb  = !eff_ref && hand_old && dirty_vec[hand] && !pend_vec[hand];
        lap_end   = (lap_cnt == IDX_W'(NF - 1));
        go_on     = lap_sched || issue_wb || (|pend_vec);
        fallback  = lap_end && !take_here && !go_on;
        take_any  = busy && (take_here || fallback);
        take_idx  = take_here ? hand : (pick_found ? pick_idx : hand_nxt);
        clr_en    = busy && eff_ref;
        pend_en   = busy && issue_wb;
    end

    // Sequencer state, lap bookkeeping and hand movement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SC_IDLE;
            hand      <= '0;
            lap_cnt   <= '0;
            lap_sched <= 1'b0;
        end else if (state == SC_IDLE) begin
            if (evict_req) begin
                state     <= SC_SCAN;
                lap_cnt   <= '0;
                lap_sched <= 1'b0;
            end
        end else begin
            if (take_any) begin
                state <= SC_IDLE;
                hand  <= ring_inc(take_idx);
            end else begin
                hand <= hand_nxt;
            end
            lap_cnt   <= lap_end ? '0 : lap_cnt + 1'b1;
            lap_sched <= lap_end ? 1'b0 : (lap_sched || issue_wb);
        end
    end

    // Registered output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_valid <= 1'b0;
            victim_frame <= '0;
            wb_req_valid <= 1'b0;
            wb_req_frame <= '0;
        end else begin
            victim_valid <= take_any;
            wb_req_valid <= pend_en;
            if (take_any) victim_frame <= take_idx;
            if (pend_en)  wb_req_frame <= hand;
        end
    end
endmodule

// File: rtl/wsclock_victim_engine.sv
// Module: top of the eviction selector; ties table, age test, clean
// picker and sequencer together.
// Assumes: one strobe of each kind per cycle; the host loads the victim.
module wsclock_victim_engine #(
    parameter int NF    = wsc_pkg::WSC_FRAMES,
    parameter int TS_W  = wsc_pkg::WSC_TIME_W,
    localparam int IDX_W = $clog2(NF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  cur_time,
    input  logic [TS_W-1:0]  tau,
    input  logic             evict_req,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             acc_write,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_frame,
    input  logic             wb_done_valid,
    input  logic [IDX_W-1:0] wb_done_frame,
    output logic             wb_req_valid,
    output logic [IDX_W-1:0] wb_req_frame,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_frame,
    output logic             busy
);
    logic [NF-1:0]           ref_vec, dirty_vec, pend_vec;
    logic [NF-1:0][TS_W-1:0] stamp_vec;
    logic [IDX_W-1:0]        hand_w, hand_nxt_w, pick_idx;
    logic                    hand_old, acc_hit, pick_found;
    logic                    clr_en, pend_en;
    logic [TS_W-1:0]         hand_stamp;

    // Stamp of the frame under the hand and same-cycle access detection.
    always_comb begin
        hand_stamp = stamp_vec[hand_w];
        acc_hit    = acc_valid && (acc_frame == hand_w);
    end

    wsc_frame_table #(.NF(NF), .TS_W(TS_W), .IDX_W(IDX_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .now        (cur_time),
        .acc_valid  (acc_valid),
        .acc_frame  (acc_frame),
        .acc_write  (acc_write),
        .load_valid (load_valid),
        .load_frame (load_frame),
        .wbd_valid  (wb_done_valid),
        .wbd_frame  (wb_done_frame),
        .clr_en     (clr_en),
        .clr_frame  (hand_w),
        .pend_en    (pend_en),
        .pend_frame (hand_w),
        .ref_vec    (ref_vec),
        .dirty_vec  (dirty_vec),
        .pend_vec   (pend_vec),
        .stamp_vec  (stamp_vec)
    );

    wsc_age_test #(.TS_W(TS_W)) u_age (
        .now    (cur_time),
        .stamp  (hand_stamp),
        .window (tau),
        .is_old (hand_old)
    );

    wsc_clean_pick #(.NF(NF), .IDX_W(IDX_W)) u_pick (
        .dirty_vec (dirty_vec),
        .start     (hand_nxt_w),
        .found     (pick_found),
        .idx       (pick_idx)
    );

    wsc_scan_ctrl #(.NF(NF), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .evict_req    (evict_req),
        .ref_vec      (ref_vec),
        .dirty_vec    (dirty_vec),
        .pend_vec     (pend_vec),
        .hand_old     (hand_old),
        .acc_hit      (acc_hit),
        .pick_found   (pick_found),
        .pick_idx     (pick_idx),
        .hand         (hand_w),
        .hand_nxt     (hand_nxt_w),
        .busy         (busy),
        .clr_en       (clr_en),
        .pend_en      (pend_en),
        .wb_req_valid (wb_req_valid),
        .wb_req_frame (wb_req_frame),
        .victim_valid (victim_valid),
        .victim_frame (victim_frame)
    );
endmodule

// File: rtl/wsc_checker.sv
// Module: temporal checks on the eviction selector, bound to its top.
// Assumes: hand is the sequencer's pointer brought out inside the top.
module wsc_checker #(
    parameter int NF    = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evict_req,
    input logic             busy,
    input logic [IDX_W-1:0] hand,
    input logic             victim_valid,
    input logic [IDX_W-1:0] victim_frame,
    input logic             wb_req_valid
);
    function automatic logic [IDX_W-1:0] ring_inc(input logic [IDX_W-1:0] x);
        return (x == IDX_W'(NF - 1)) ? '0 : x + 1'b1;
    endfunction

    // R2: a search starts only from a request.
    p_start_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(evict_req));

    // R2: while searching, the hand steps one frame per cycle.
    p_scan_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (hand == ring_inc($past(hand))));

    // R2: the hand rests while idle.
    p_hand_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(hand));

    // R5: the victim strobe lasts one cycle and ends the search.
    p_victim_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (!busy ##1 !victim_valid));

    // R6: writeback requests only arise mid-search, never with a victim.
    p_wb_mid_scan_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_valid |-> (busy && !victim_valid));

    // R9: the hand rests just past the chosen victim.
    p_hand_past_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (hand == ring_inc(victim_frame)));
endmodule

bind wsclock_victim_engine wsc_checker #(.NF(NF), .IDX_W(IDX_W)) u_wsc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .evict_req    (evict_req),
    .busy         (busy),
    .hand         (hand_w),
    .victim_valid (victim_valid),
    .victim_frame (victim_frame),
    .wb_req_valid (wb_req_valid)
);

// File: tb/test_wsclock_victim_engine.sv
module test_wsclock_victim_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cur_time = '0;
    logic [15:0] tau = '0;
    logic        evict_req = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_frame = '0;
    logic        acc_write = 1'b0;
    logic        load_valid = 1'b0;
    logic [2:0]  load_frame = '0;
    logic        wb_done_valid = 1'b0;
    logic [2:0]  wb_done_frame = '0;
    logic        wb_req_valid;
    logic [2:0]  wb_req_frame;
    logic        victim_valid;
    logic [2:0]  victim_frame;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int wb_cnt = 0;
    int wb_first = -1;
    int vic_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    wsclock_victim_engine i_wsclock_victim_engine (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .tau(tau),
        .evict_req(evict_req), .acc_valid(acc_valid), .acc_frame(acc_frame),
        .acc_write(acc_write), .load_valid(load_valid), .load_frame(load_frame),
        .wb_done_valid(wb_done_valid), .wb_done_frame(wb_done_frame),
        .wb_req_valid(wb_req_valid), .wb_req_frame(wb_req_frame),
        .victim_valid(victim_valid), .victim_frame(victim_frame), .busy(busy)
    );

    // Writeback responder: completes each request one cycle later.
    always @(negedge clk) begin
        if (wb_req_valid) begin
            wb_done_valid = 1'b1;
            wb_done_frame = wb_req_frame;
            if (wb_first < 0) wb_first = int'(wb_req_frame);
            wb_cnt++;
        end else begin
            wb_done_valid = 1'b0;
        end
        if (victim_valid) vic_cnt++;
    end

    // Table: {old mask, referenced mask, modified mask, victim, latency}.
    // Old frames loaded at t=0, young at t=1000; window 100; now 1000.
    localparam logic [35:0] VEC [9] = '{
        36'hFF_00_00_0_01,   // R5: first frame old and clean
        36'hFF_03_00_2_03,   // R3: two referenced frames skipped
        36'hFF_FF_03_2_08,   // R8: fallback to first clean
        36'hFF_FF_FF_0_08,   // R8: none clean, hand frame
        36'hF0_00_00_4_05,   // R4: young frames skipped
        36'h00_00_00_0_08,   // R8: all young, all clean
        36'h00_07_07_3_08,   // R8/R10: writes mark frames modified
        36'h80_00_00_7_08,   // R5: last frame of lap taken directly
        36'hFF_0F_0F_4_05    // R3: referenced dirty frames skipped
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        evict_req = 1'b0; acc_valid = 1'b0; load_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wb_cnt = 0; wb_first = -1; vic_cnt = 0;
    endtask

    task automatic do_load(input int f);
        load_valid = 1'b1; load_frame = 3'(f);
        @(posedge clk); @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic do_access(input int f, input bit w);
        acc_valid = 1'b1; acc_frame = 3'(f); acc_write = w;
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Request, optionally hit frame acc_f in the first examination cycle.
    task automatic run_evict(input int acc_f, output int v, output int lat);
        evict_req = 1'b1;
        @(posedge clk); @(negedge clk);
        evict_req = 1'b0;
        if (acc_f >= 0) begin acc_valid = 1'b1; acc_frame = 3'(acc_f); end
        lat = 0; v = -1;
        while (lat < 300) begin
            @(posedge clk); lat++;
            @(negedge clk);
            acc_valid = 1'b0;
            if (victim_valid) begin v = int'(victim_frame); break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2: watchdog actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, lat;
        // R1: reset state at the ports, then reset table contents.
        do_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 victim strobe", int'(victim_valid), 0);
        chk("R1 wb strobe", int'(wb_req_valid), 0);
        cur_time = 16'd0; tau = 16'd0;
        run_evict(-1, v, lat);
        chk("R1 victim from hand 0", v, 0);
        chk("R1 all young lap", lat, 8);

        // Vector table walk.
        for (int i = 0; i < 9; i++) begin
            logic [7:0] om, rm, dm;
            om = VEC[i][35:28]; rm = VEC[i][27:20]; dm = VEC[i][19:12];
            do_reset();
            tau = 16'd100; cur_time = 16'd0;
            for (int f = 0; f < 8; f++) if (om[f]) do_load(f);
            cur_time = 16'd1000;
            for (int f = 0; f < 8; f++) if (!om[f]) do_load(f);
            for (int f = 0; f < 8; f++) if (rm[f]) do_access(f, dm[f]);
            run_evict(-1, v, lat);
            chk($sformatf("R5/R8 vector %0d victim", i), v, int'(VEC[i][11:8]));
            chk($sformatf("R2 vector %0d latency", i), lat, int'(VEC[i][7:0]));
            chk($sformatf("R6 vector %0d no writeback", i), wb_cnt, 0);
        end

        // R9: hand moves past the victim; next search starts there.
        do_reset();
        cur_time = 16'd1000; tau = 16'd100;
        run_evict(-1, v, lat);
        chk("R9 first victim", v, 0);
        run_evict(-1, v, lat);
        chk("R9 next victim", v, 1);
        chk("R9 next latency", lat, 1);

        // R2: requests during a search are ignored.
        do_reset();
        cur_time = 16'd0; tau = 16'd0;
        evict_req = 1'b1;
        repeat (4) begin @(posedge clk); @(negedge clk); end
        evict_req = 1'b0;
        repeat (20) @(negedge clk);
        chk("R2 single victim while held", vic_cnt, 1);
        chk("R2 idle afterwards", int'(busy), 0);

        // R4: wrapping age, strictly greater than the window.
        do_reset();
        cur_time = 16'hFFF0; do_load(0);
        cur_time = 16'h0005; tau = 16'h0010;
        run_evict(-1, v, lat);
        chk("R4 wrapped age old victim", v, 0);
        chk("R4 wrapped age old latency", lat, 1);
        do_reset();
        cur_time = 16'hFFF0; do_load(0);
        cur_time = 16'h0005; tau = 16'h0015;
        run_evict(-1, v, lat);
        chk("R4 age equal window is young", lat, 8);

        // R6/R10: old modified frames written back, reloaded frame taken.
        do_reset();
        cur_time = 16'd1000; tau = 16'd100;
        for (int f = 0; f < 8; f++) do_access(f, 1'b1);
        run_evict(-1, v, lat);
        chk("R8 all modified takes hand frame", v, 0);
        do_load(0);
        cur_time = 16'd5000;
        wb_cnt = 0; wb_first = -1;
        run_evict(-1, v, lat);
        chk("R6 writeback count", wb_cnt, 7);
        chk("R6 first writeback frame", wb_first, 1);
        chk("R10 reloaded frame is clean victim", v, 0);
        chk("R6 latency", lat, 8);

        // R7: writeback on the lap's last frame forces another lap.
        do_reset();
        cur_time = 16'd1000; tau = 16'd100;
        for (int f = 0; f < 8; f++) do_access(f, 1'b1);
        run_evict(-1, v, lat);
        cur_time = 16'd5000;
        wb_cnt = 0;
        run_evict(-1, v, lat);
        chk("R7 writebacks over a lap", wb_cnt, 8);
        chk("R7 victim in second lap", v, 1);
        chk("R7 second lap latency", lat, 9);

        // R11: access to the examined frame in that cycle protects it.
        do_reset();
        cur_time = 16'd1000; tau = 16'd100;
        run_evict(0, v, lat);
        chk("R11 accessed frame skipped", v, 1);
        chk("R11 latency", lat, 2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule